// File: doc/BRIEF.md
# Burst DMA Request Scheduler

This block sits between a pixel staging buffer and a DMA engine. It watches how many words the buffer holds and, when enough data is present, raises a one-cycle request asking the engine to move one burst of a set number of words. Only one burst may be in flight. The engine reports the end of each burst with a completion strobe. Bursts are counted into blocks, and the block raises a pulse when the last burst of a block completes.

Burst length and block size arrive on configuration inputs that act as shadow values. The block works from live copies of them. A mode input chooses when the live copies are refreshed: at the end of each block, or when a new frame starts. Every refresh produces a pulse that a status bit elsewhere can latch. After each completed burst a programmable idle gap must pass before the next request. Requests can be held off while frame information is being read, and nothing is requested unless the global enable is set.

Top module: `burst_req_sched`

## Requirements
- R1: After reset req_o, blk_done_o and cfg_upd_o are 0, and req_len_o shows the reset burst length of 128 words, with a live block size of 8191 bursts.
- R2: A request is issued only when buf_level_i is at least req_len_o. req_o is high for exactly one cycle, the cycle after the clock edge that saw the condition met.
- R3: After a request, no further request is issued until burst_done_i is seen while that request is outstanding.
- R4: After an accepted burst_done_i, the next request is delayed by G cycles, where G is the bit index of the highest set bit of gap_cfg_i plus one (so a thermometer code gives its count of ones, 16'hFFFF gives 16, and zero gives no gap). With no gap the request appears two cycles after the cycle burst_done_i was high.
- R5: The accepted burst_done_i that completes the live block size of bursts makes blk_done_o high for one cycle in the following cycle, and starts a new block count.
- R6: With upd_by_blk_i = 1, the live burst length and block size load from the configuration inputs at the end of each block, and cfg_upd_o pulses in the same cycle as blk_done_o; frame_start_i then loads nothing and gives no cfg_upd_o.
- R7: With upd_by_blk_i = 0, frame_start_i loads the live burst length and block size and pulses cfg_upd_o in the following cycle; frame_start_i in either mode restarts the burst count of the block.
- R8: While mask_on_rd_i and frame_info_rd_i are both 1, no request is issued.
- R9: While enable_i is 0, no request is issued.
- R10: A configured burst length of zero is used as one word, and req_len_o then reads 1.
- R11: burst_done_i with no request outstanding is ignored: it does not start the gap and does not count a burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Global enable for requests |
| buf_level_i | input | 14 | Words currently held in the pixel buffer |
| frame_start_i | input | 1 | One-cycle pulse at the start of a frame |
| frame_info_rd_i | input | 1 | High while frame information is being read |
| mask_on_rd_i | input | 1 | Hold off requests during frame information reads |
| upd_by_blk_i | input | 1 | 1: refresh live config at block end; 0: at frame start |
| burst_len_cfg_i | input | 12 | Shadow burst length in words |
| blk_size_cfg_i | input | 13 | Shadow block size in bursts |
| gap_cfg_i | input | 16 | Thermometer-coded idle gap between requests |
| burst_done_i | input | 1 | Burst completion strobe from the DMA engine |
| req_o | output | 1 | One-cycle burst request strobe |
| req_len_o | output | 12 | Live effective burst length for the request |
| blk_done_o | output | 1 | One-cycle pulse when a block completes |
| cfg_upd_o | output | 1 | One-cycle pulse when live config is refreshed |

## Verification
The bench builds the block with its default widths (12-bit length, 13-bit block size, 14-bit level, 16-bit gap field) and the reset values 128 and 8191. Since block size and length are runtime inputs, loading a block size of 3 or 2 through a frame start brings several block boundaries and both refresh modes within a few dozen cycles, and the full 16-bit gap field lets the widest gap and a non-thermometer value be measured exactly.

// File: rtl/brs_pkg.sv
package brs_pkg;
    // source of a live configuration refresh
    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_FRAME = 2'd1,
        LD_BLOCK = 2'd2
    } load_src_e;
endpackage

// File: rtl/brs_gap_timer.sv
module brs_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GAP_W-1:0] gap_cfg_i,
    input  logic             start_i,
    output logic             idle_o
);
    localparam int SPAN_W = $clog2(GAP_W + 1);

    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] cnt_d, cnt_q;

    // per-bit candidate: bit i set means a span of i+1
    logic [SPAN_W-1:0] cand [GAP_W];
    genvar gi;
    generate
        for (gi = 0; gi < GAP_W; gi++) begin : g_cand
            assign cand[gi] = gap_cfg_i[gi] ? SPAN_W'(gi + 1) : '0;
        end
    endgenerate

    always_comb begin
        span = '0;
        for (int i = 0; i < GAP_W; i++) begin
            if (cand[i] != '0) span = cand[i];
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)            cnt_d = span;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idle_o = (cnt_q == '0);
endmodule

// File: rtl/brs_cfg_live.sv
module brs_cfg_live #(
    parameter int LEN_W   = 12,
    parameter int BLK_W   = 13,
    parameter int LEN_RST = 128,
    parameter int BLK_RST = 8191
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_cfg_i,
    input  logic [BLK_W-1:0] blk_cfg_i,
    output logic [LEN_W-1:0] len_o,
    output logic [BLK_W-1:0] blk_o,
    output logic             upd_o
);
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [BLK_W-1:0] blk;
        logic             upd;
    } live_t;

    live_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = load_i;
        if (load_i) begin
            st_d.len = (len_cfg_i == '0) ? LEN_W'(1) : len_cfg_i;
            st_d.blk = blk_cfg_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.len <= LEN_W'(LEN_RST);
            st_q.blk <= BLK_W'(BLK_RST);
            st_q.upd <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_o = st_q.len;
    assign blk_o = st_q.blk;
    assign upd_o = st_q.upd;
endmodule

// File: rtl/brs_blk_count.sv
module brs_blk_count #(
    parameter int BLK_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [BLK_W-1:0] size_i,
    output logic             last_o,
    output logic             done_o
);
    typedef struct packed {
        logic [BLK_W-1:0] cnt;
        logic             done;
    } cnt_t;

    cnt_t st_d, st_q;
    logic [BLK_W:0] next_cnt;

    assign next_cnt = {1'b0, st_q.cnt} + 1'b1;
    assign last_o   = step_i && (next_cnt >= {1'b0, size_i});

    always_comb begin
        st_d      = st_q;
        st_d.done = last_o;
        if (step_i) st_d.cnt = last_o ? '0 : next_cnt[BLK_W-1:0];
        if (clear_i) st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
endmodule

// File: rtl/burst_req_sched.sv
module burst_req_sched #(
    parameter int LEN_W   = 12,
    parameter int BLK_W   = 13,
    parameter int LVL_W   = 14,
    parameter int GAP_W   = 16,
    parameter int LEN_RST = 128,
    parameter int BLK_RST = 8191
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [LVL_W-1:0] buf_level_i,
    input  logic             frame_start_i,
    input  logic             frame_info_rd_i,
    input  logic             mask_on_rd_i,
    input  logic             upd_by_blk_i,
    input  logic [LEN_W-1:0] burst_len_cfg_i,
    input  logic [BLK_W-1:0] blk_size_cfg_i,
    input  logic [GAP_W-1:0] gap_cfg_i,
    input  logic             burst_done_i,
    output logic             req_o,
    output logic [LEN_W-1:0] req_len_o,
    output logic             blk_done_o,
    output logic             cfg_upd_o
);
    import brs_pkg::*;

    localparam int CMP_W = (LVL_W > LEN_W) ? LVL_W : LEN_W;

    typedef struct packed {
        logic req;
        logic pend;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [LEN_W-1:0] live_len;
    logic [BLK_W-1:0] live_blk;
    logic             gap_idle;
    logic             accept;
    logic             blk_last;
    logic             issue;
    logic             masked;
    logic             level_ok;
    load_src_e        ld_src;

    assign accept   = burst_done_i && st_q.pend;
    assign masked   = mask_on_rd_i && frame_info_rd_i;
    assign level_ok = CMP_W'(buf_level_i) >= CMP_W'(live_len);
    assign issue    = enable_i && !st_q.pend && gap_idle && level_ok && !masked;

    always_comb begin
        if (upd_by_blk_i) ld_src = blk_last ? LD_BLOCK : LD_NONE;
        else              ld_src = frame_start_i ? LD_FRAME : LD_NONE;
    end

    always_comb begin
        st_d     = st_q;
        st_d.req = issue;
        if (issue)       st_d.pend = 1'b1;
        else if (accept) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    brs_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .gap_cfg_i (gap_cfg_i),
        .start_i   (accept),
        .idle_o    (gap_idle)
    );

    brs_cfg_live #(
        .LEN_W   (LEN_W),
        .BLK_W   (BLK_W),
        .LEN_RST (LEN_RST),
        .BLK_RST (BLK_RST)
    ) u_live (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ld_src != LD_NONE),
        .len_cfg_i (burst_len_cfg_i),
        .blk_cfg_i (blk_size_cfg_i),
        .len_o     (live_len),
        .blk_o     (live_blk),
        .upd_o     (cfg_upd_o)
    );

    brs_blk_count #(.BLK_W(BLK_W)) u_blk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (frame_start_i),
        .step_i  (accept),
        .size_i  (live_blk),
        .last_o  (blk_last),
        .done_o  (blk_done_o)
    );

    assign req_o     = st_q.req;
    assign req_len_o = live_len;
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
    parameter int LEN_W = 12,
    parameter int LVL_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic [LVL_W-1:0] buf_level_i,
    input logic             frame_start_i,
    input logic             frame_info_rd_i,
    input logic             mask_on_rd_i,
    input logic             upd_by_blk_i,
    input logic             burst_done_i,
    input logic             req_o,
    input logic [LEN_W-1:0] req_len_o,
    input logic             blk_done_o,
    input logic             cfg_upd_o
);
    localparam int CMP_W = (LVL_W > LEN_W) ? LVL_W : LEN_W;

    // independent record of an in-flight burst
    logic pend_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q || req_o) && !burst_done_i;
    end

    // R2
    req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (CMP_W'($past(buf_level_i)) >= CMP_W'($past(req_len_o))));
    // R2
    req_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);
    // R3
    one_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> !pend_q);
    // R8
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> !($past(mask_on_rd_i) && $past(frame_info_rd_i)));
    // R9
    enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(enable_i));
    // R10
    len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_len_o != '0);
    // R5
    blk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done_o |-> $past(burst_done_i));
    // R6
    upd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_upd_o |-> (($past(frame_start_i) && !$past(upd_by_blk_i)) ||
                       (blk_done_o && $past(upd_by_blk_i))));
    // R7
    len_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_upd_o |-> $stable(req_len_o));
endmodule

bind burst_req_sched brs_checker #(.LEN_W(LEN_W), .LVL_W(LVL_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enable_i        (enable_i),
    .buf_level_i     (buf_level_i),
    .frame_start_i   (frame_start_i),
    .frame_info_rd_i (frame_info_rd_i),
    .mask_on_rd_i    (mask_on_rd_i),
    .upd_by_blk_i    (upd_by_blk_i),
    .burst_done_i    (burst_done_i),
    .req_o           (req_o),
    .req_len_o       (req_len_o),
    .blk_done_o      (blk_done_o),
    .cfg_upd_o       (cfg_upd_o)
);

// File: tb/sim_burst_req_sched.sv
module sim_burst_req_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic [13:0] buf_level_i = '0;
    logic        frame_start_i = 1'b0;
    logic        frame_info_rd_i = 1'b0;
    logic        mask_on_rd_i = 1'b0;
    logic        upd_by_blk_i = 1'b0;
    logic [11:0] burst_len_cfg_i = 12'd128;
    logic [12:0] blk_size_cfg_i = 13'd8191;
    logic [15:0] gap_cfg_i = '0;
    logic        burst_done_i = 1'b0;
    logic        req_o;
    logic [11:0] req_len_o;
    logic        blk_done_o;
    logic        cfg_upd_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    burst_req_sched u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .buf_level_i(buf_level_i),
        .frame_start_i(frame_start_i), .frame_info_rd_i(frame_info_rd_i),
        .mask_on_rd_i(mask_on_rd_i), .upd_by_blk_i(upd_by_blk_i),
        .burst_len_cfg_i(burst_len_cfg_i), .blk_size_cfg_i(blk_size_cfg_i),
        .gap_cfg_i(gap_cfg_i), .burst_done_i(burst_done_i), .req_o(req_o),
        .req_len_o(req_len_o), .blk_done_o(blk_done_o), .cfg_upd_o(cfg_upd_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // count negedges (up to lim) until req_o is seen; -1 if never
    task automatic wait_req(input int lim, output int n);
        n = -1;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (req_o && n < 0) n = i;
            if (n >= 0) break;
        end
    endtask

    // complete the outstanding burst, then count negedges to the next request
    task automatic finish_burst(input int lim, output int n, output bit bd, output bit cu);
        n = -1;
        burst_done_i = 1'b1;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            burst_done_i = 1'b0;
            if (i == 1) begin
                bd = blk_done_o;
                cu = cfg_upd_o;
            end
            if (req_o) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic frame_pulse(output bit cu);
        frame_start_i = 1'b1;
        @(negedge clk);
        frame_start_i = 1'b0;
        cu = cfg_upd_o;
    endtask

    task automatic t_reset;
        int n;
        check("R1 req_o", req_o, 0);
        check("R1 blk_done_o", blk_done_o, 0);
        check("R1 cfg_upd_o", cfg_upd_o, 0);
        check("R1 req_len_o", req_len_o, 128);
        buf_level_i = 14'd300;
        wait_req(6, n);
        check("R9 no req while disabled", n, -1);
    endtask

    task automatic t_level;
        int n;
        buf_level_i = 14'd127;
        enable_i = 1'b1;
        wait_req(6, n);
        check("R2 no req below length", n, -1);
        buf_level_i = 14'd128;
        wait_req(6, n);
        check("R2 req at level equal length", n, 1);
        @(negedge clk);
        check("R2 req one cycle", req_o, 0);
    endtask

    task automatic t_single;
        int n;
        bit bd, cu;
        wait_req(8, n);
        check("R3 no second req while pending", n, -1);
        finish_burst(40, n, bd, cu);
        check("R4 no-gap latency", n, 2);
    endtask

    task automatic t_gap;
        int n;
        bit bd, cu;
        gap_cfg_i = 16'h0001;
        finish_burst(40, n, bd, cu);
        check("R4 gap one", n, 3);
        gap_cfg_i = 16'h000F;
        finish_burst(40, n, bd, cu);
        check("R4 gap four", n, 6);
        gap_cfg_i = 16'hFFFF;
        finish_burst(40, n, bd, cu);
        check("R4 gap sixteen", n, 18);
        gap_cfg_i = 16'h0104;
        finish_burst(40, n, bd, cu);
        check("R4 non-thermometer gap", n, 11);
    endtask

    task automatic t_ignore;
        int n;
        bit bd, cu;
        gap_cfg_i = 16'hFFFF;
        buf_level_i = '0;
        finish_burst(30, n, bd, cu);
        check("R2 no req with empty buffer", n, -1);
        // stray completion with nothing outstanding
        burst_done_i = 1'b1;
        @(negedge clk);
        burst_done_i = 1'b0;
        buf_level_i = 14'd128;
        wait_req(30, n);
        check("R11 stray done starts no gap", n, 1);
    endtask

    task automatic t_frame_mode;
        int n;
        bit bd, cu;
        gap_cfg_i = '0;
        upd_by_blk_i = 1'b0;
        burst_len_cfg_i = 12'd4;
        blk_size_cfg_i = 13'd3;
        frame_pulse(cu);
        check("R7 cfg_upd on frame start", cu, 1);
        check("R7 length loaded", req_len_o, 4);
        @(negedge clk);
        check("R7 cfg_upd one cycle", cfg_upd_o, 0);
        finish_burst(20, n, bd, cu);
        check("R5 no block end after 1", bd, 0);
        finish_burst(20, n, bd, cu);
        check("R5 no block end after 2", bd, 0);
        finish_burst(20, n, bd, cu);
        check("R5 block end after 3", bd, 1);
        check("R7 no cfg_upd at block end in frame mode", cu, 0);
        finish_burst(20, n, bd, cu);
        check("R5 new block counted", bd, 0);
    endtask

    task automatic t_block_mode;
        int n;
        bit bd, cu;
        upd_by_blk_i = 1'b1;
        burst_len_cfg_i = 12'd8;
        blk_size_cfg_i = 13'd2;
        frame_pulse(cu);
        check("R6 frame start ignored in block mode", cu, 0);
        check("R6 length kept", req_len_o, 4);
        finish_burst(20, n, bd, cu);
        check("R7 frame start restarted count", bd, 0);
        finish_burst(20, n, bd, cu);
        check("R7 frame start restarted count 2", bd, 0);
        finish_burst(20, n, bd, cu);
        check("R6 block end", bd, 1);
        check("R6 cfg_upd with block end", cu, 1);
        check("R6 new length", req_len_o, 8);
        finish_burst(20, n, bd, cu);
        check("R6 new size first", bd, 0);
        finish_burst(20, n, bd, cu);
        check("R6 new size 2 ends block", bd, 1);
    endtask

    task automatic t_mask;
        int n;
        bit bd, cu;
        mask_on_rd_i = 1'b1;
        frame_info_rd_i = 1'b1;
        finish_burst(10, n, bd, cu);
        check("R8 masked during info read", n, -1);
        frame_info_rd_i = 1'b0;
        wait_req(6, n);
        check("R8 req after read ends", n, 1);
        mask_on_rd_i = 1'b0;
    endtask

    task automatic t_zero_len;
        int n;
        bit bd, cu;
        buf_level_i = '0;
        finish_burst(8, n, bd, cu);
        upd_by_blk_i = 1'b0;
        burst_len_cfg_i = 12'd0;
        frame_pulse(cu);
        check("R10 zero length reads one", req_len_o, 1);
        wait_req(4, n);
        check("R10 no req with empty buffer", n, -1);
        buf_level_i = 14'd1;
        wait_req(6, n);
        check("R10 req with one word", n, 1);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_level;
        t_single;
        t_gap;
        t_ignore;
        t_frame_mode;
        t_block_mode;
        t_mask;
        t_zero_len;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule